// File: doc/BRIEF.md
# Quadrature Stall Checker

This block watches a two-channel quadrature encoder fitted to a stepper motor and compares the measured motion with the step pulses that the step generator commands. The encoder channels are brought into the clock domain and decoded at four counts per encoder cycle into a signed position. At the same time, the block counts the commanded step pulses.

Every twelve encoder counts in one direction form a checkpoint. One encoder cycle corresponds to 32 microsteps, so a healthy motor shows 96 steps per checkpoint. If the motor falls behind or stalls, the step count rises above 96. If it spins the wrong way, the direction disagrees with the command.

Each checkpoint that misses the expected count by more than a tolerance, or that disagrees in direction, adds one to a mismatch tally. Ten mismatches are tolerated. The eleventh latches a fault that tells the motion logic to stop driving the motor. The fault stays set until a clear arrives while the fault is present.

The window logic is a three-state machine:
- MON_IDLE: no window is open.
- MON_TRACK: a window is collecting same-direction counts.
- MON_FAULT: motion is disabled.

Its transitions are:
- open: MON_IDLE to MON_TRACK, on any decoded count.
- extend: MON_TRACK to MON_TRACK, on a same-direction count below the twelfth.
- restart: MON_TRACK to MON_TRACK, on an opposite-direction count.
- close: MON_TRACK to MON_IDLE, on the twelfth count without a trip.
- trip: MON_TRACK to MON_FAULT, on the twelfth count when the mismatch limit is already reached and this checkpoint also mismatches.
- release: MON_FAULT to MON_IDLE, on `clear_req`.

Top module: `stall_watch`

## Requirements
- R1: `enc_a` and `enc_b` pass through a two-flop synchronizer. A change driven just after one rising edge shows in `pos_count` after the third rising edge that follows, and not before.
- R2: Decoding is x4 with {A,B} treated as a 2-bit code. The sequence 00, 10, 11, 01, 00 adds one per step (A leads B, which is the forward direction). The reverse order subtracts one. `pos_count` wraps modulo 2^POS_W.
- R3: When both channels change between two synchronized samples, `pos_count` does not move, no count is produced, and `quad_err_cnt` rises by one, saturating at its maximum.
- R4: `check_stb` pulses for exactly one cycle, one clock after the decoded twelfth count of a window. An opposite-direction count restarts the window and counts as its first entry. A window also starts empty after every checkpoint.
- R5: The step counter counts `step_pulse` cycles since the last checkpoint, restart, or release, saturating at its maximum. A pulse in the checkpoint cycle belongs to the closing window. The counter is zeroed by a checkpoint or a restart.
- R6: A checkpoint mismatches when its step count lies outside 96 ± STEP_TOL (default 2, so 94 through 98 pass), or when the window direction differs from `step_dir`. `step_dir` is 1 for forward. Each mismatch raises `mismatch_cnt` by one, and the tally is cumulative across checkpoints.
- R7: A mismatching checkpoint while `mismatch_cnt` equals 10 sets `fault`, and `mismatch_cnt` reads 11. While `fault` is set, no checkpoint occurs and the tally holds.
- R8: `fault` stays set until `clear_req` is high in a clock while it is set. On that clock `fault` and `mismatch_cnt` return to 0. `clear_req` with no fault present has no effect on any output.
- R9: After reset, `pos_count`, `mismatch_cnt` and `quad_err_cnt` are 0, and `check_stb` and `fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder channel A, asynchronous |
| enc_b | input | 1 | Encoder channel B, asynchronous |
| step_pulse | input | 1 | One-cycle pulse per commanded microstep |
| step_dir | input | 1 | Commanded direction, 1 = forward |
| clear_req | input | 1 | Releases a latched fault |
| pos_count | output | POS_W | Signed decoded position |
| check_stb | output | 1 | One-cycle checkpoint strobe |
| mismatch_cnt | output | MIS_W | Cumulative mismatch tally |
| fault | output | 1 | Latched stall fault; motion must stop |
| quad_err_cnt | output | ERR_W | Saturating count of invalid transitions |

## Verification
A corrupted previous-sample register in the decoder shows up in `pos_count` or `quad_err_cnt` on the very next decoded transition, three clocks after the encoder edge. A wrong window counter or window direction is hidden until the checkpoint. It then appears as a `check_stb` in the wrong cycle, or as one that never comes, at most twelve counts later. A wrong step count or tally reaches the ports only at the next checkpoint, through `mismatch_cnt` or `fault`. For that reason the reference model is compared on every clock, and the windows straddle the tolerance limits.

// File: rtl/stall_watch_pkg.sv
package stall_watch_pkg;

    typedef enum logic [1:0] {
        MON_IDLE  = 2'd0,
        MON_TRACK = 2'd1,
        MON_FAULT = 2'd2
    } mon_state_t;

    typedef enum logic [1:0] {
        QM_NONE = 2'd0,
        QM_UP   = 2'd1,
        QM_DOWN = 2'd2,
        QM_BAD  = 2'd3
    } quad_move_t;

    // Position of a {A,B} code along the forward cycle 00,10,11,01.
    function automatic logic [1:0] quad_phase(input logic [1:0] ab);
        return {ab[0], ab[1] ^ ab[0]};
    endfunction

    function automatic quad_move_t quad_classify(input logic [1:0] old_ab,
                                                 input logic [1:0] new_ab);
        logic [1:0] step;
        step = quad_phase(new_ab) - quad_phase(old_ab);
        unique case (step)
            2'd0:    return QM_NONE;
            2'd1:    return QM_UP;
            2'd3:    return QM_DOWN;
            default: return QM_BAD;
        endcase
    endfunction

endpackage

// File: rtl/quad_sync.sv
module quad_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_chan
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], din[g]};
            end
        end

        assign dout[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/quad_decode.sv
module quad_decode
    import stall_watch_pkg::*;
#(
    parameter int POS_W = 16,
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_s,
    input  logic             b_s,
    output logic [POS_W-1:0] pos_q,
    output logic             edge_vld,
    output logic             edge_up,
    output logic [ERR_W-1:0] err_q
);

    logic [1:0] prev_q;
    quad_move_t move;

    assign move = quad_classify(prev_q, {a_s, b_s});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q   <= 2'b00;
            pos_q    <= '0;
            edge_vld <= 1'b0;
            edge_up  <= 1'b0;
            err_q    <= '0;
        end else begin
            prev_q   <= {a_s, b_s};
            edge_vld <= (move == QM_UP) || (move == QM_DOWN);
            edge_up  <= (move == QM_UP);
            unique case (move)
                QM_UP:   pos_q <= pos_q + POS_W'(1);
                QM_DOWN: pos_q <= pos_q - POS_W'(1);
                QM_BAD:  if (err_q != {ERR_W{1'b1}}) err_q <= err_q + ERR_W'(1);
                default: ;
            endcase
        end
    end

    // R2: the position never moves by more than one count per clock
    assert_pos_unit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q != $past(pos_q)) |->
            ((POS_W'(pos_q - $past(pos_q)) == POS_W'(1)) ||
             (POS_W'($past(pos_q) - pos_q) == POS_W'(1))));

    // R2: a reported count always goes with a position change
    assert_edge_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
        edge_vld |-> (pos_q != $past(pos_q)));

    // R3: an invalid transition leaves the position alone and yields no count
    assert_bad_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q != $past(err_q)) |-> ((pos_q == $past(pos_q)) && !edge_vld));

endmodule

// File: rtl/window_monitor.sv
module window_monitor
    import stall_watch_pkg::*;
#(
    parameter int EDGES_PER_CHECK = 12,
    parameter int STEPS_PER_CHECK = 96,
    parameter int STEP_TOL        = 2,
    parameter int MAX_MISMATCH    = 10,
    parameter int MIS_W           = $clog2(MAX_MISMATCH + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_vld,
    input  logic             edge_up,
    input  logic             step_pulse,
    input  logic             step_dir,
    input  logic             clear_req,
    output logic             check_stb,
    output logic [MIS_W-1:0] mis_q,
    output logic             fault_q
);

    localparam int EDGE_W = $clog2(EDGES_PER_CHECK + 1);
    localparam int STEP_W = $clog2(2 * STEPS_PER_CHECK + 1);
    localparam int HI_LIM = STEPS_PER_CHECK + STEP_TOL;
    localparam int LO_LIM = STEPS_PER_CHECK - STEP_TOL;

    mon_state_t        state_q, state_d;
    logic [EDGE_W-1:0] win_cnt_q;
    logic              win_up_q;
    logic [STEP_W-1:0] steps_q, steps_inc;
    logic              same_dir, win_last, do_check, rate_bad, dir_bad, bad, trip;

    assign steps_inc = (step_pulse && (steps_q != {STEP_W{1'b1}})) ?
                       steps_q + STEP_W'(1) : steps_q;
    assign same_dir  = (win_up_q == edge_up);
    assign win_last  = (win_cnt_q == EDGE_W'(EDGES_PER_CHECK - 1));
    assign do_check  = (state_q == MON_TRACK) && edge_vld && same_dir && win_last;
    assign rate_bad  = (int'(steps_inc) > HI_LIM) || (int'(steps_inc) < LO_LIM);
    assign dir_bad   = (edge_up != step_dir);
    assign bad       = rate_bad || dir_bad;
    assign trip      = do_check && bad && (mis_q == MIS_W'(MAX_MISMATCH));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MON_IDLE:  if (edge_vld) state_d = MON_TRACK;
            MON_TRACK: if (do_check) state_d = trip ? MON_FAULT : MON_IDLE;
            MON_FAULT: if (clear_req) state_d = MON_IDLE;
            default:   state_d = MON_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MON_IDLE;
        else        state_q <= state_d;
    end

    // window, step and tally registers and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt_q <= '0;
            win_up_q  <= 1'b0;
            steps_q   <= '0;
            mis_q     <= '0;
            fault_q   <= 1'b0;
            check_stb <= 1'b0;
        end else begin
            check_stb <= do_check;
            unique case (state_q)
                MON_IDLE: begin
                    steps_q <= steps_inc;
                    if (edge_vld) begin
                        win_cnt_q <= EDGE_W'(1);
                        win_up_q  <= edge_up;
                    end
                end
                MON_TRACK: begin
                    if (!edge_vld) begin
                        steps_q <= steps_inc;
                    end else if (!same_dir) begin
                        win_cnt_q <= EDGE_W'(1);
                        win_up_q  <= edge_up;
                        steps_q   <= '0;
                    end else if (win_last) begin
                        win_cnt_q <= '0;
                        steps_q   <= '0;
                        if (bad) mis_q <= mis_q + MIS_W'(1);
                        if (trip) fault_q <= 1'b1;
                    end else begin
                        win_cnt_q <= win_cnt_q + EDGE_W'(1);
                        steps_q   <= steps_inc;
                    end
                end
                MON_FAULT: begin
                    win_cnt_q <= '0;
                    steps_q   <= '0;
                    if (clear_req) begin
                        mis_q   <= '0;
                        fault_q <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    // R4: a checkpoint strobe is never longer than one cycle
    assert_chk_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        check_stb |=> !check_stb);

    // R6: outside a fault the tally only advances by one, at a checkpoint
    assert_mis_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(fault_q) && (mis_q != $past(mis_q))) |->
            ((mis_q == MIS_W'($past(mis_q) + 1'b1)) && check_stb));

    // R7: the fault rises exactly on the mismatch past the limit
    assert_trip_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_q) |-> (mis_q == MIS_W'(MAX_MISMATCH + 1)));

    // R7: no checkpoint is reported while the fault is held
    assert_quiet_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fault_q) |-> !check_stb);

    // R8: the fault stays latched without a clear
    assert_fault_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q && !clear_req) |=> fault_q);

endmodule

// File: rtl/stall_watch.sv
module stall_watch #(
    parameter int POS_W           = 16,
    parameter int ERR_W           = 8,
    parameter int SYNC_STAGES     = 2,
    parameter int EDGES_PER_CHECK = 12,
    parameter int STEPS_PER_CHECK = 96,
    parameter int STEP_TOL        = 2,
    parameter int MAX_MISMATCH    = 10,
    localparam int MIS_W          = $clog2(MAX_MISMATCH + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic             step_pulse,
    input  logic             step_dir,
    input  logic             clear_req,
    output logic [POS_W-1:0] pos_count,
    output logic             check_stb,
    output logic [MIS_W-1:0] mismatch_cnt,
    output logic             fault,
    output logic [ERR_W-1:0] quad_err_cnt
);

    logic [1:0] ab_sync;
    logic       edge_vld, edge_up;

    quad_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({enc_a, enc_b}),
        .dout  (ab_sync)
    );

    quad_decode #(
        .POS_W (POS_W),
        .ERR_W (ERR_W)
    ) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_s      (ab_sync[1]),
        .b_s      (ab_sync[0]),
        .pos_q    (pos_count),
        .edge_vld (edge_vld),
        .edge_up  (edge_up),
        .err_q    (quad_err_cnt)
    );

    window_monitor #(
        .EDGES_PER_CHECK (EDGES_PER_CHECK),
        .STEPS_PER_CHECK (STEPS_PER_CHECK),
        .STEP_TOL        (STEP_TOL),
        .MAX_MISMATCH    (MAX_MISMATCH),
        .MIS_W           (MIS_W)
    ) u_monitor (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_vld   (edge_vld),
        .edge_up    (edge_up),
        .step_pulse (step_pulse),
        .step_dir   (step_dir),
        .clear_req  (clear_req),
        .check_stb  (check_stb),
        .mis_q      (mismatch_cnt),
        .fault_q    (fault)
    );

endmodule

// File: tb/stall_watch_bench.sv
`timescale 1ns/1ps
module stall_watch_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_a = 1'b0, enc_b = 1'b0;
    logic        step_pulse = 1'b0, step_dir = 1'b1, clear_req = 1'b0;
    logic [15:0] pos_count;
    logic        check_stb, fault;
    logic [3:0]  mismatch_cnt;
    logic [7:0]  quad_err_cnt;

    int checks = 0, errors = 0, cycles = 0, chk_seen = 0;
    int idx = 0;
    bit cmp_on = 0, done = 0;

    always #2.5 clk = ~clk;

    stall_watch u_stall_watch (
        .clk (clk), .rst_n (rst_n), .enc_a (enc_a), .enc_b (enc_b),
        .step_pulse (step_pulse), .step_dir (step_dir), .clear_req (clear_req),
        .pos_count (pos_count), .check_stb (check_stb), .mismatch_cnt (mismatch_cnt),
        .fault (fault), .quad_err_cnt (quad_err_cnt)
    );

    function automatic logic [1:0] code_of(input int p);
        case (p & 3)
            0: return 2'b00;
            1: return 2'b10;
            2: return 2'b11;
            default: return 2'b01;
        endcase
    endfunction

    function automatic int phase_of(input logic [1:0] ab);
        case (ab)
            2'b00: return 0;
            2'b10: return 1;
            2'b11: return 2;
            default: return 3;
        endcase
    endfunction

    // ---------------- behavioural reference ----------------
    logic [1:0] h1 = 0, h2 = 0, h3 = 0;
    int  m_pos = 0, m_err = 0, m_mis = 0, m_wcnt = 0, m_steps = 0;
    bit  m_ev = 0, m_up = 0, m_wup = 0, m_fault = 0, m_chk = 0;

    always @(posedge clk) begin
        int ns, d;
        bit bad;
        if (!rst_n) begin
            h1 = 0; h2 = 0; h3 = 0;
            m_pos = 0; m_err = 0; m_mis = 0; m_wcnt = 0; m_steps = 0;
            m_ev = 0; m_up = 0; m_wup = 0; m_fault = 0; m_chk = 0;
        end else begin
            m_chk = 0;
            if (m_fault) begin
                if (clear_req) begin m_fault = 0; m_mis = 0; end
                m_steps = 0; m_wcnt = 0;
            end else begin
                ns = m_steps + (step_pulse ? 1 : 0);
                if (ns > 255) ns = 255;
                if (m_ev) begin
                    if (m_wcnt == 0 || m_up == m_wup) begin
                        m_wup = m_up;
                        m_wcnt++;
                        if (m_wcnt == 12) begin
                            m_chk = 1; m_wcnt = 0; m_steps = 0;
                            bad = (ns > 98) || (ns < 94) || (m_up != step_dir);
                            if (bad) begin
                                m_mis++;
                                if (m_mis == 11) m_fault = 1;
                            end
                        end else m_steps = ns;
                    end else begin
                        m_wup = m_up; m_wcnt = 1; m_steps = 0;
                    end
                end else m_steps = ns;
            end
            d = (phase_of(h2) - phase_of(h3) + 4) % 4;
            m_ev = (d == 1) || (d == 3);
            m_up = (d == 1);
            if (d == 1) m_pos++;
            else if (d == 3) m_pos--;
            else if (d == 2 && m_err < 255) m_err++;
            h3 = h2; h2 = h1; h1 = {enc_a, enc_b};
        end
    end

    task automatic expect_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    // per-clock comparison against the reference, away from the active edge
    always @(negedge clk) begin
        if (check_stb) chk_seen++;
        if (rst_n && cmp_on) begin
            expect_eq("R2", "pos_count", int'(pos_count), int'(16'(m_pos)));
            expect_eq("R3", "quad_err_cnt", int'(quad_err_cnt), m_err);
            expect_eq("R4", "check_stb", int'(check_stb), int'(m_chk));
            expect_eq("R6", "mismatch_cnt", int'(mismatch_cnt), m_mis);
            expect_eq("R7", "fault", int'(fault), int'(m_fault));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 100000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic enc_move(input bit up);
        @(negedge clk);
        idx = up ? idx + 1 : idx + 3;
        {enc_a, enc_b} = code_of(idx);
        repeat (6) @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) step_pulse = 1'b1;
            @(negedge clk) step_pulse = 1'b0;
        end
    endtask

    task automatic window(input bit up, input int n);
        pulses(n);
        repeat (12) enc_move(up);
    endtask

    initial begin
        int c0;
        repeat (5) @(negedge clk);
        // R9: reset values
        expect_eq("R9", "pos_count", int'(pos_count), 0);
        expect_eq("R9", "mismatch_cnt", int'(mismatch_cnt), 0);
        expect_eq("R9", "quad_err_cnt", int'(quad_err_cnt), 0);
        expect_eq("R9", "check_stb", int'(check_stb), 0);
        expect_eq("R9", "fault", int'(fault), 0);
        rst_n = 1'b1;
        cmp_on = 1;
        repeat (3) @(negedge clk);

        // R1: synchronizer latency, first count of the first window
        @(negedge clk);
        idx = 1;
        {enc_a, enc_b} = code_of(idx);
        @(posedge clk); @(posedge clk); #1;
        expect_eq("R1", "pos before 3rd edge", int'(pos_count), 0);
        @(posedge clk); #1;
        expect_eq("R1", "pos after 3rd edge", int'(pos_count), 1);
        repeat (6) @(negedge clk);
        pulses(96);
        repeat (11) enc_move(1'b1);
        expect_eq("R4", "checkpoints", chk_seen, 1);
        expect_eq("R5", "mismatch after 96 steps", int'(mismatch_cnt), 0);

        window(1'b1, 96);
        expect_eq("R2", "pos forward", int'(pos_count), 24);

        // R6: tolerance edges
        window(1'b1, 98);
        window(1'b1, 94);
        expect_eq("R6", "mismatch inside tolerance", int'(mismatch_cnt), 0);
        window(1'b1, 99);
        expect_eq("R6", "mismatch at 99", int'(mismatch_cnt), 1);
        window(1'b1, 93);
        expect_eq("R6", "mismatch at 93", int'(mismatch_cnt), 2);
        step_dir = 1'b0;
        window(1'b1, 96);
        expect_eq("R6", "direction mismatch", int'(mismatch_cnt), 3);

        // R2: reverse motion
        window(1'b0, 96);
        expect_eq("R2", "pos after reverse", int'(pos_count), 72);
        expect_eq("R6", "reverse good", int'(mismatch_cnt), 3);

        // R4/R5: restart on opposite count
        step_dir = 1'b1;
        repeat (5) enc_move(1'b1);
        c0 = chk_seen;
        step_dir = 1'b0;
        enc_move(1'b0);
        pulses(96);
        repeat (10) enc_move(1'b0);
        expect_eq("R4", "no checkpoint before 12 same-dir", chk_seen, c0);
        enc_move(1'b0);
        expect_eq("R4", "checkpoint after restart", chk_seen, c0 + 1);
        expect_eq("R5", "steps since restart", int'(mismatch_cnt), 3);
        expect_eq("R2", "pos after restart", int'(pos_count), 65);

        // R8: clear with no fault is ignored
        @(negedge clk) clear_req = 1'b1;
        @(negedge clk) clear_req = 1'b0;
        repeat (3) @(negedge clk);
        expect_eq("R8", "clear ignored tally", int'(mismatch_cnt), 3);
        expect_eq("R8", "clear ignored fault", int'(fault), 0);

        // R3: both channels change together
        @(negedge clk);
        idx = idx + 2;
        {enc_a, enc_b} = code_of(idx);
        repeat (6) @(negedge clk);
        expect_eq("R3", "error count", int'(quad_err_cnt), 1);
        expect_eq("R3", "pos unchanged", int'(pos_count), 65);

        // R7: lagging motor reaches the limit, then trips
        step_dir = 1'b1;
        repeat (7) window(1'b1, 120);
        expect_eq("R7", "tally at limit", int'(mismatch_cnt), 10);
        expect_eq("R7", "no fault at limit", int'(fault), 0);
        window(1'b1, 120);
        expect_eq("R7", "fault latched", int'(fault), 1);
        expect_eq("R7", "tally after trip", int'(mismatch_cnt), 11);
        c0 = chk_seen;
        window(1'b1, 96);
        expect_eq("R7", "no checkpoint in fault", chk_seen, c0);
        expect_eq("R8", "fault held", int'(fault), 1);

        // R8: release
        @(negedge clk) clear_req = 1'b1;
        @(negedge clk) clear_req = 1'b0;
        expect_eq("R8", "fault released", int'(fault), 0);
        expect_eq("R8", "tally released", int'(mismatch_cnt), 0);
        window(1'b1, 96);
        expect_eq("R8", "checking resumes", chk_seen, c0 + 1);
        expect_eq("R8", "clean after release", int'(mismatch_cnt), 0);

        repeat (5) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule